// File: doc/BRIEF.md
# Strided Vector Bank Access Scheduler

This block drives one vector load or store into a memory built from independent, interleaved banks. A start pulse latches a word base address, a two's-complement stride and an element count. From then on the block walks the elements in index order and forms each word address from the base plus the index times the stride. It sends each element to the bank picked by the low address bits. It issues at most one request per cycle, and only when the target bank has recovered from its previous access. Otherwise it holds the element and counts a stall cycle.

Accepted requests travel down a tag pipeline whose depth equals the memory's fixed read latency. Each returning word is therefore presented together with the element index it belongs to, and the vector register file can write it into the right slot. Once every element has come back, a single-cycle completion pulse fires. The stall count stays readable until the next start, so how the stride relates to the bank count can be measured directly.

The controller has four states. IDLE waits for start. It goes to ISSUE when the length is non-zero and straight to FIN when the length is zero. ISSUE sends elements and goes to DRAIN once the last element is accepted. DRAIN waits for the outstanding returns and goes to FIN in the cycle after the final return. FIN raises the completion pulse for one cycle and always goes back to IDLE.

Top module: `vbank_sched`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `wr_valid` and `done` are 0, and `stall_cnt` is 0.
- R2: Element i is requested at word address `base + i*stride`, modulo 2^AW, with `stride` read as two's complement. Elements are requested in ascending index order starting at 0, with at most one request per cycle.
- R3: `req_bank` equals the low log2(NBANK) bits of `req_addr` (bits 3:0 with 16 banks).
- R4: A bank that was accessed in cycle t accepts no further request before cycle t+BUSY (t+4). Each element is issued in the earliest cycle that is both after the previous element's issue and at least 4 cycles after the last access to its bank. The first element issues in the cycle after start is sampled.
- R5: An odd stride with 16 banks issues one element per cycle with no stall cycles.
- R6: `stall_cnt` is cleared at start and increments in every ISSUE cycle in which the pending element is held back. It keeps its value after completion until the next start.
- R7: `wr_valid` rises exactly LAT (12) cycles after the request for that element. In that cycle `wr_idx` is the element's index and `wr_data` carries `mem_rdata`.
- R8: `done` is high for exactly one cycle, in the cycle after the last return. `busy` is 0 from the following cycle on.
- R9: A length of 0 produces no requests and raises `done` in the cycle after start. A length above MAXVL (64) on the 7-bit `vlen` input is treated as 64.
- R10: `start` is ignored while `busy` is high. The running transfer keeps its base, stride and length.
- R11: A stride of 0 sends every element to the same bank, with BUSY-1 (3) stall cycles before each element after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| base | input | AW | Word address of element 0 |
| stride | input | AW | Two's-complement word stride |
| vlen | input | IW (7) | Element count, 0..127, clamped to MAXVL |
| busy | output | 1 | Transfer in progress |
| req_valid | output | 1 | Request issued to memory this cycle |
| req_addr | output | AW | Word address of the issued element |
| req_bank | output | BW (4) | Bank index of the issued element |
| req_idx | output | IW | Element index of the issued element |
| mem_rdata | input | DW | Read data from memory, LAT cycles after the request |
| wr_valid | output | 1 | Returned element valid |
| wr_idx | output | IW | Element index of the returned word |
| wr_data | output | DW | Returned word |
| done | output | 1 | One-cycle completion pulse |
| stall_cnt | output | SCW | Stall cycles of the latest transfer |

## Verification
The bench builds the block with 16 banks, a 4-cycle bank recovery, a 12-cycle return latency and a 64-element maximum length. With these values, strides 8 and 16 collide on two banks and on one bank, while odd strides, unit stride and negative stride spread over all 16. A zero stride exposes the full recovery gap, and a 64-element run wraps the banks four times. The bench predicts every issue cycle with its own greedy bank-recovery model. From those predictions it derives the exact stall total, the cycle of each return and the completion cycle.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } vbs_state_e;
endpackage

// File: rtl/vbs_addr_gen.sv
// Element index and address walker: loads base and stride, steps on accept.
module vbs_addr_gen #(
    parameter int AW = 32,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] addr,
    output logic [IW-1:0] idx
);
    logic [AW-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            idx      <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr     <= base;
            idx      <= '0;
            stride_q <= stride;
        end else if (adv) begin
            addr     <= addr + stride_q;
            idx      <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/vbs_bank_timers.sv
// One recovery timer per bank; a bank is free when its timer reads zero.
module vbs_bank_timers #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic [$clog2(NBANK)-1:0] sel,
    output logic [NBANK-1:0]         free
);
    localparam int BW = $clog2(NBANK);
    localparam int TW = $clog2(BUSY + 1);
    localparam logic [TW-1:0] RELOAD = TW'(BUSY - 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [TW-1:0] tmr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tmr_q <= '0;
            end else if (fire && (sel == BW'(g))) begin
                tmr_q <= RELOAD;
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
        assign free[g] = (tmr_q == '0);
    end
endmodule

// File: rtl/vbs_ret_pipe.sv
// Fixed-latency tag pipeline: carries element index alongside outstanding reads.
module vbs_ret_pipe #(
    parameter int LAT = 12,
    parameter int IW  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [IW-1:0] in_idx,
    output logic          out_vld,
    output logic [IW-1:0] out_idx
);
    logic          vld_q [LAT];
    logic [IW-1:0] idx_q [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    idx_q[g] <= '0;
                end else begin
                    vld_q[g] <= in_vld;
                    idx_q[g] <= in_idx;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    idx_q[g] <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    idx_q[g] <= idx_q[g-1];
                end
            end
        end
    end

    assign out_vld = vld_q[LAT-1];
    assign out_idx = idx_q[LAT-1];
endmodule

// File: rtl/vbank_sched.sv
module vbank_sched
    import vbs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NBANK = 16,
    parameter int BUSY  = 4,
    parameter int LAT   = 12,
    parameter int MAXVL = 64,
    parameter int SCW   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [AW-1:0]               base,
    input  logic [AW-1:0]               stride,
    input  logic [$clog2(MAXVL+1)-1:0]  vlen,
    output logic                        busy,
    output logic                        req_valid,
    output logic [AW-1:0]               req_addr,
    output logic [$clog2(NBANK)-1:0]    req_bank,
    output logic [$clog2(MAXVL+1)-1:0]  req_idx,
    input  logic [DW-1:0]               mem_rdata,
    output logic                        wr_valid,
    output logic [$clog2(MAXVL+1)-1:0]  wr_idx,
    output logic [DW-1:0]               wr_data,
    output logic                        done,
    output logic [SCW-1:0]              stall_cnt
);
    localparam int BW = $clog2(NBANK);
    localparam int IW = $clog2(MAXVL + 1);
    localparam logic [IW-1:0] VL_CAP = IW'(MAXVL);

    vbs_state_e     state_q, state_d;
    logic [IW-1:0]  vl_q;
    logic [IW-1:0]  vl_eff;
    logic [IW-1:0]  ret_cnt_q;
    logic [SCW-1:0] stall_q;
    logic [AW-1:0]  cur_addr;
    logic [IW-1:0]  cur_idx;
    logic [BW-1:0]  cur_bank;
    logic [NBANK-1:0] bank_free;
    logic           load;
    logic           in_issue;
    logic           issue;
    logic           hold;
    logic           last_elem;
    logic           ret_vld;
    logic [IW-1:0]  ret_idx;
    logic           last_ret;

    assign vl_eff    = (vlen > VL_CAP) ? VL_CAP : vlen;
    assign load      = (state_q == ST_IDLE) && start;
    assign in_issue  = (state_q == ST_ISSUE);
    assign cur_bank  = cur_addr[BW-1:0];
    assign issue     = in_issue && bank_free[cur_bank];
    assign hold      = in_issue && !bank_free[cur_bank];
    assign last_elem = (cur_idx == vl_q - 1'b1);
    assign last_ret  = ret_vld && (ret_cnt_q == vl_q - 1'b1);

    vbs_addr_gen #(.AW(AW), .IW(IW)) addr_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (issue),
        .base   (base),
        .stride (stride),
        .addr   (cur_addr),
        .idx    (cur_idx)
    );

    vbs_bank_timers #(.NBANK(NBANK), .BUSY(BUSY)) timers_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (issue),
        .sel   (cur_bank),
        .free  (bank_free)
    );

    vbs_ret_pipe #(.LAT(LAT), .IW(IW)) ret_pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (issue),
        .in_idx  (cur_idx),
        .out_vld (ret_vld),
        .out_idx (ret_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (vl_eff == '0) ? ST_FIN : ST_ISSUE;
            ST_ISSUE: if (issue && last_elem) state_d = ST_DRAIN;
            ST_DRAIN: if (last_ret) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q      <= '0;
            ret_cnt_q <= '0;
            stall_q   <= '0;
        end else if (load) begin
            vl_q      <= vl_eff;
            ret_cnt_q <= '0;
            stall_q   <= '0;
        end else begin
            if (ret_vld)                 ret_cnt_q <= ret_cnt_q + 1'b1;
            if (hold && (stall_q != '1)) stall_q   <= stall_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FIN);
        req_valid = issue;
        req_addr  = cur_addr;
        req_bank  = cur_bank;
        req_idx   = cur_idx;
        wr_valid  = ret_vld;
        wr_idx    = ret_idx;
        wr_data   = mem_rdata;
        stall_cnt = stall_q;
    end
endmodule

// File: rtl/vbank_sched_chk.sv
module vbank_sched_chk #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4,
    parameter int IW    = 7,
    parameter int SCW   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     req_valid,
    input logic [$clog2(NBANK)-1:0] req_bank,
    input logic [IW-1:0]            req_idx,
    input logic                     wr_valid,
    input logic [IW-1:0]            wr_idx,
    input logic                     done,
    input logic [SCW-1:0]           stall_cnt
);
    localparam int AGW = $clog2(BUSY + 1);
    localparam logic [AGW-1:0] AGE_MAX = AGW'(BUSY);

    logic [AGW-1:0] age [NBANK];
    logic [IW-1:0]  wcnt;
    logic [IW-1:0]  last_idx;
    logic           seen_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) age[b] <= AGE_MAX;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (req_valid && (int'(req_bank) == b)) age[b] <= AGW'(1);
                else if (age[b] < AGE_MAX)             age[b] <= age[b] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt     <= '0;
            last_idx <= '0;
            seen_req <= 1'b0;
        end else if (!busy && start) begin
            wcnt     <= '0;
            seen_req <= 1'b0;
        end else begin
            if (wr_valid) wcnt <= wcnt + 1'b1;
            if (req_valid) begin
                last_idx <= req_idx;
                seen_req <= 1'b1;
            end
        end
    end

    AST_BANK_RECOVERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> age[req_bank] >= AGE_MAX);                       // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seen_req) |-> req_idx == last_idx + 1'b1);         // R2
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_idx == wcnt);                                    // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !wr_valid));                            // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(stall_cnt));                       // R6
endmodule

bind vbank_sched vbank_sched_chk #(
    .NBANK (NBANK),
    .BUSY  (BUSY),
    .IW    ($clog2(MAXVL + 1)),
    .SCW   (SCW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .req_idx   (req_idx),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .done      (done),
    .stall_cnt (stall_cnt)
);

// File: tb/vbank_sched_tb_top.sv
`timescale 1ns/1ps
module vbank_sched_tb_top;
    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic        busy, req_valid, wr_valid, done;
    logic [31:0] req_addr, wr_data, mem_rdata;
    logic [3:0]  req_bank;
    logic [6:0]  req_idx, wr_idx;
    logic [15:0] stall_cnt;

    always #2.5 clk = ~clk;

    vbank_sched dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .vlen(vlen), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
        .req_bank(req_bank), .req_idx(req_idx), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .done(done),
        .stall_cnt(stall_cnt)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // Fixed-latency memory model
    logic [31:0] dq [LAT];
    always @(posedge clk) begin
        dq[0] <= req_valid ? mem_word(req_addr) : 32'h0;
        for (int k = 1; k < LAT; k++) dq[k] <= dq[k-1];
    end
    assign mem_rdata = dq[LAT-1];

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    typedef struct {
        int          idx;
        logic [31:0] addr;
        longint      t;
    } req_item_t;
    typedef struct {
        int          idx;
        logic [31:0] data;
        longint      t;
    } ret_item_t;

    req_item_t req_q[$];
    ret_item_t ret_q[$];
    int        done_cnt = 0;
    longint    done_t = 0;

    // Monitor: compares observed requests/returns with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (req_valid) begin
                if (req_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected request idx", req_idx, -1);
                end else begin
                    req_item_t e;
                    ret_item_t r;
                    e = req_q.pop_front();
                    chk(req_idx == 7'(e.idx), "R2", "req idx", req_idx, e.idx);
                    chk(req_addr == e.addr, "R2", "req addr", req_addr, e.addr);
                    chk(req_bank == e.addr[3:0], "R3", "req bank", req_bank, e.addr[3:0]);
                    chk(cyc == e.t, "R4", "issue cycle", cyc, e.t);
                    r.idx = e.idx;
                    r.data = mem_word(e.addr);
                    r.t = cyc + LAT;
                    ret_q.push_back(r);
                end
            end
            if (wr_valid) begin
                if (ret_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected return idx", wr_idx, -1);
                end else begin
                    ret_item_t r;
                    r = ret_q.pop_front();
                    chk(wr_idx == 7'(r.idx), "R7", "ret idx", wr_idx, r.idx);
                    chk(wr_data == r.data, "R7", "ret data", wr_data, r.data);
                    chk(cyc == r.t, "R7", "ret cycle", cyc, r.t);
                end
            end
            if (done) begin
                done_cnt++;
                done_t = cyc;
            end
        end
    end

    // Driver: predicts the schedule, pushes it, launches the transfer
    task automatic run(input logic [31:0] b, input logic [31:0] s, input int vl_in,
                       input bit poke, input string rq);
        int     vl;
        longint lastb [16];
        longint prev, first, t0, exp_done, exp_stall;
        int     waited;
        vl = (vl_in > 64) ? 64 : vl_in;
        @(negedge clk);
        t0 = cyc;
        for (int k = 0; k < 16; k++) lastb[k] = -1000;
        prev = t0;
        first = t0 + 1;
        for (int i = 0; i < vl; i++) begin
            req_item_t e;
            longint t;
            e.addr = b + 32'(i) * s;
            e.idx = i;
            t = prev + 1;
            if (lastb[e.addr[3:0]] + 4 > t) t = lastb[e.addr[3:0]] + 4;
            e.t = t;
            lastb[e.addr[3:0]] = t;
            prev = t;
            req_q.push_back(e);
        end
        exp_stall = (vl == 0) ? 0 : (prev - first - (vl - 1));
        exp_done = (vl == 0) ? t0 + 1 : prev + LAT + 1;
        done_cnt = 0;
        base = b; stride = s; vlen = 7'(vl_in); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: a second start with other values while the transfer runs
            repeat (2) @(negedge clk);
            base = 32'h7777_0000; stride = 32'd5; vlen = 7'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, rq, "done pulses (R8)", done_cnt, 1);
        chk(done_t == exp_done, rq, "done cycle (R8)", done_t, exp_done);
        chk(busy == 1'b0, rq, "busy after done (R8)", busy, 0);
        chk(stall_cnt == 16'(exp_stall), rq, "stall count (R6)", stall_cnt, exp_stall);
        chk(req_q.size() == 0, rq, "requests missing (R2)", req_q.size(), 0);
        chk(ret_q.size() == 0, rq, "returns missing (R7)", ret_q.size(), 0);
        req_q.delete();
        ret_q.delete();
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(req_valid == 1'b0 && wr_valid == 1'b0, "R1", "req/wr in reset", req_valid, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(stall_cnt == 16'd0, "R1", "stall_cnt in reset", stall_cnt, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && req_valid == 1'b0, "R1", "idle after reset", busy, 0);

        run(32'h0000_1000, 32'd1, 16, 1'b0, "R5");            // unit stride, no stalls
        run(32'h0000_2003, 32'd3, 64, 1'b0, "R5");            // odd stride, full length
        run(32'h0000_0040, 32'd8, 10, 1'b0, "R4");            // two-bank collisions
        run(32'h0000_0100, 32'd16, 4, 1'b0, "R4");            // one bank
        run(32'h0000_0007, 32'd0, 5, 1'b0, "R11");            // zero stride: 12 stalls
        run(32'h0000_0005, 32'hFFFF_FFFF, 20, 1'b0, "R2");    // negative stride wraps
        run(32'h0000_0300, 32'd2, 12, 1'b0, "R2");            // even, 8 banks
        run(32'h0000_0000, 32'd4, 0, 1'b0, "R9");             // zero length
        run(32'h0000_0800, 32'd1, 70, 1'b0, "R9");            // clamp to 64
        run(32'h0000_0900, 32'd8, 8, 1'b1, "R10");            // start while busy

        // R6: stall count held after completion
        repeat (10) @(negedge clk);
        chk(stall_cnt == 16'd6, "R6", "stall_cnt held", stall_cnt, 6);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule